// File: doc/BRIEF.md
# Dual Data Pointer Address Unit

This unit keeps two 16-bit data pointers and an 8-bit page register for an 8051-style core. It also forms the external data memory address. A one-bit select register decides which pointer is active. Every pointer operation uses only that pointer: a load from the decoder, an increment, a byte write over the special-function-register (SFR) port, and address generation. Toggling the select bit moves between the two pointers. The contents of neither pointer change when it does.

Two kinds of external access are supported. A pointer-based access places the active pointer on the 16-bit address output. A register-indirect access combines two values: the page register forms the upper byte, and the 8-bit indirect register value (R0 or R1, supplied by the core) forms the lower byte. The address output is combinational from the registered state and the mode and indirect-value inputs. SFR read data is registered and returned one cycle after the address is presented.

Top module: `ddp_addr_unit`

## Requirements
- R1: A synchronous active-high reset clears both pointers, the select register, the page register and the registered read data to zero.
- R2: A write to the select register at SFR address 0x92 stores only bit 0 of the write data. Bits 7:1 of that register always read as zero.
- R3: Writing the select register never alters the contents of either pointer.
- R4: When `ptr_load` is high, `ptr_load_val` is written into the pointer chosen by the select value before the clock edge. The other pointer keeps its value.
- R5: When `ptr_inc` is high and `ptr_load` is low, the selected pointer increases by one, and 0xFFFF wraps to 0x0000. The other pointer is unchanged.
- R6: An SFR write to 0x82 replaces the low byte of the selected pointer, and an SFR write to 0x83 replaces its high byte. The other byte and the other pointer are kept.
- R7: `sfr_rdata` gives, one cycle after `sfr_addr` is presented, the value before that edge of the addressed register. The registers are: 0x82 and 0x83 for the low and high bytes of the selected pointer, 0x92 for the select register, and 0xBF for the page register. Any other address reads 0x00.
- R8: With `xaddr_indirect` low, `xaddr` equals the currently selected pointer in the same cycle.
- R9: With `xaddr_indirect` high, `xaddr` is formed with the page register as bits 15:8 and `ri_val` as bits 7:0.
- R10: In one cycle, a load takes precedence over an increment, which takes precedence over an SFR byte write to the pointer. A losing operation is dropped.
- R11: An SFR write to address 0xBF stores all eight bits in the page register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sfr_addr | input | 8 | SFR address for read and write |
| sfr_wdata | input | 8 | SFR write data |
| sfr_we | input | 1 | SFR write strobe |
| sfr_rdata | output | 8 | Registered SFR read data |
| ptr_load | input | 1 | Load selected pointer |
| ptr_load_val | input | 16 | Value for a pointer load |
| ptr_inc | input | 1 | Increment selected pointer |
| xaddr_indirect | input | 1 | 1: register-indirect address, 0: pointer address |
| ri_val | input | 8 | Indirect register value (low address byte) |
| xaddr | output | 16 | External data memory address |

## Verification
On every cycle, the assertions check the following behaviours: read-as-zero select bits, the load and increment results seen on the pointer address output (including wrap), the page byte reaching the indirect address, and the cleared state after reset. Some behaviours can only be shown by the bench's scenarios, which compare against a behavioural model. These are: select toggling leaving both pointers intact, SFR byte writes landing in the selected pointer only, the zero returned from unimplemented addresses, and the same-cycle priority among load, increment and byte write.

// File: rtl/ddp_pkg.sv
package ddp_pkg;
  localparam logic [7:0] SFR_PTR_LO = 8'h82;
  localparam logic [7:0] SFR_PTR_HI = 8'h83;
  localparam logic [7:0] SFR_SELECT = 8'h92;
  localparam logic [7:0] SFR_PAGE   = 8'hBF;

  typedef enum logic [1:0] {
    BYTE_NONE = 2'd0,
    BYTE_LO   = 2'd1,
    BYTE_HI   = 2'd2
  } byte_wr_e;
endpackage

// File: rtl/ddp_ptr_bank.sv
module ddp_ptr_bank #(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int NUM_PTR = 2,
  localparam int SEL_W  = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  sel,
  input  logic              load,
  input  logic [AW-1:0]     load_val,
  input  logic              inc,
  input  ddp_pkg::byte_wr_e byte_wr,
  input  logic [DW-1:0]     byte_val,
  output logic [AW-1:0]     sel_ptr
);
  import ddp_pkg::*;

  logic [AW-1:0] ptr_q [NUM_PTR];

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
    logic hit;
    assign hit = (sel == SEL_W'(i));
    always_ff @(posedge clk) begin
      if (rst) begin
        ptr_q[i] <= '0;
      end else if (hit) begin
        if (load) begin
          ptr_q[i] <= load_val;
        end else if (inc) begin
          ptr_q[i] <= ptr_q[i] + AW'(1);
        end else if (byte_wr == BYTE_LO) begin
          ptr_q[i] <= {ptr_q[i][AW-1:DW], byte_val};
        end else if (byte_wr == BYTE_HI) begin
          ptr_q[i] <= {byte_val, ptr_q[i][DW-1:0]};
        end
      end
    end
  end

  assign sel_ptr = ptr_q[sel];
endmodule

// File: rtl/ddp_sfr_regs.sv
module ddp_sfr_regs #(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int NUM_PTR = 2,
  localparam int SEL_W  = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        addr,
  input  logic [DW-1:0]     wdata,
  input  logic              we,
  input  logic [AW-1:0]     sel_ptr,
  output logic [SEL_W-1:0]  sel,
  output logic [DW-1:0]     page,
  output ddp_pkg::byte_wr_e byte_wr,
  output logic [DW-1:0]     rdata
);
  import ddp_pkg::*;

  logic [SEL_W-1:0] sel_q;
  logic [DW-1:0]    page_q;
  logic [DW-1:0]    rdata_q;
  logic [DW-1:0]    rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      page_q <= '0;
    end else if (we) begin
      if (addr == SFR_SELECT) sel_q  <= wdata[SEL_W-1:0];
      if (addr == SFR_PAGE)   page_q <= wdata;
    end
  end

  always_comb begin
    byte_wr = BYTE_NONE;
    if (we && addr == SFR_PTR_LO) byte_wr = BYTE_LO;
    if (we && addr == SFR_PTR_HI) byte_wr = BYTE_HI;
  end

  always_comb begin
    unique case (addr)
      SFR_PTR_LO: rd_mux = sel_ptr[DW-1:0];
      SFR_PTR_HI: rd_mux = sel_ptr[AW-1:DW];
      SFR_SELECT: rd_mux = {{(DW-SEL_W){1'b0}}, sel_q};
      SFR_PAGE:   rd_mux = page_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign sel   = sel_q;
  assign page  = page_q;
  assign rdata = rdata_q;
endmodule

// File: rtl/ddp_addr_gen.sv
module ddp_addr_gen #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          indirect,
  input  logic [AW-1:0] sel_ptr,
  input  logic [DW-1:0] page,
  input  logic [DW-1:0] ri_val,
  output logic [AW-1:0] xaddr
);
  always_comb begin
    if (indirect) xaddr = {page, ri_val};
    else          xaddr = sel_ptr;
  end
endmodule

// File: rtl/ddp_addr_unit.sv
module ddp_addr_unit #(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int NUM_PTR = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [7:0]    sfr_addr,
  input  logic [DW-1:0] sfr_wdata,
  input  logic          sfr_we,
  output logic [DW-1:0] sfr_rdata,
  input  logic          ptr_load,
  input  logic [AW-1:0] ptr_load_val,
  input  logic          ptr_inc,
  input  logic          xaddr_indirect,
  input  logic [DW-1:0] ri_val,
  output logic [AW-1:0] xaddr
);
  localparam int SEL_W = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1;

  logic [SEL_W-1:0]  sel;
  logic [DW-1:0]     page;
  logic [AW-1:0]     sel_ptr;
  ddp_pkg::byte_wr_e byte_wr;

  ddp_sfr_regs #(.AW(AW), .DW(DW), .NUM_PTR(NUM_PTR)) regs_i (
    .clk(clk), .rst(rst), .addr(sfr_addr), .wdata(sfr_wdata), .we(sfr_we),
    .sel_ptr(sel_ptr), .sel(sel), .page(page), .byte_wr(byte_wr),
    .rdata(sfr_rdata)
  );

  ddp_ptr_bank #(.AW(AW), .DW(DW), .NUM_PTR(NUM_PTR)) bank_i (
    .clk(clk), .rst(rst), .sel(sel), .load(ptr_load), .load_val(ptr_load_val),
    .inc(ptr_inc), .byte_wr(byte_wr), .byte_val(sfr_wdata), .sel_ptr(sel_ptr)
  );

  ddp_addr_gen #(.AW(AW), .DW(DW)) agen_i (
    .indirect(xaddr_indirect), .sel_ptr(sel_ptr), .page(page),
    .ri_val(ri_val), .xaddr(xaddr)
  );
endmodule

// File: rtl/ddp_addr_unit_chk.sv
module ddp_addr_unit_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [7:0]    sfr_addr,
  input logic [DW-1:0] sfr_wdata,
  input logic          sfr_we,
  input logic [DW-1:0] sfr_rdata,
  input logic          ptr_load,
  input logic [AW-1:0] ptr_load_val,
  input logic          ptr_inc,
  input logic          xaddr_indirect,
  input logic [DW-1:0] ri_val,
  input logic [AW-1:0] xaddr
);
  import ddp_pkg::*;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (sfr_rdata == '0) && (xaddr_indirect || xaddr == '0)); // R1

  AST_SELECT_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (sfr_addr == SFR_SELECT) |=> (sfr_rdata[DW-1:1] == '0)); // R2

  AST_LOAD_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    (ptr_load && !sfr_we) |=> (xaddr_indirect || xaddr == $past(ptr_load_val))); // R4

  AST_INC_WRAPS: assert property (@(posedge clk) disable iff (rst)
    (ptr_inc && !ptr_load && !sfr_we && !xaddr_indirect)
      |=> (xaddr_indirect || xaddr == AW'($past(xaddr) + AW'(1)))); // R5

  AST_PAGE_ON_ADDR: assert property (@(posedge clk) disable iff (rst)
    (sfr_we && sfr_addr == SFR_PAGE)
      |=> (!xaddr_indirect || xaddr[AW-1:DW] == $past(sfr_wdata))); // R11
endmodule

bind ddp_addr_unit ddp_addr_unit_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
  .sfr_we(sfr_we), .sfr_rdata(sfr_rdata), .ptr_load(ptr_load),
  .ptr_load_val(ptr_load_val), .ptr_inc(ptr_inc),
  .xaddr_indirect(xaddr_indirect), .ri_val(ri_val), .xaddr(xaddr)
);

// File: tb/ddp_addr_unit_tb.sv
module ddp_addr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  sfr_addr, sfr_wdata, sfr_rdata, ri_val;
  logic        sfr_we, ptr_load, ptr_inc, xaddr_indirect;
  logic [15:0] ptr_load_val, xaddr;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;
  string tag = "R1";

  int m_ptr [2];
  int m_sel, m_page, m_rd;

  always #5 clk = ~clk;

  ddp_addr_unit dut_i (
    .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_we(sfr_we), .sfr_rdata(sfr_rdata), .ptr_load(ptr_load),
    .ptr_load_val(ptr_load_val), .ptr_inc(ptr_inc),
    .xaddr_indirect(xaddr_indirect), .ri_val(ri_val), .xaddr(xaddr)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int model_rd(int a);
    case (a)
      8'h82:   return m_ptr[m_sel] & 8'hFF;
      8'h83:   return (m_ptr[m_sel] >> 8) & 8'hFF;
      8'h92:   return m_sel;
      8'hBF:   return m_page;
      default: return 0;
    endcase
  endfunction

  // one cycle: drive at negedge, check address, edge, update model, check read data
  task automatic step(bit ld, int lv, bit inc, bit we, int a, int wd, bit ind, int ri);
    int s;
    ptr_load = ld; ptr_load_val = 16'(lv); ptr_inc = inc;
    sfr_we = we; sfr_addr = 8'(a); sfr_wdata = 8'(wd);
    xaddr_indirect = ind; ri_val = 8'(ri);
    #1;
    if (ind) check("R9", int'(xaddr), (m_page << 8) | (ri & 8'hFF));
    else     check("R8", int'(xaddr), m_ptr[m_sel]);
    @(posedge clk);
    m_rd = model_rd(a & 8'hFF);
    s = m_sel;
    if (ld) m_ptr[s] = lv & 16'hFFFF;
    else if (inc) m_ptr[s] = (m_ptr[s] + 1) & 16'hFFFF;
    else if (we && a == 8'h82) m_ptr[s] = (m_ptr[s] & 16'hFF00) | (wd & 8'hFF);
    else if (we && a == 8'h83) m_ptr[s] = (m_ptr[s] & 16'h00FF) | ((wd & 8'hFF) << 8);
    if (we && a == 8'h92) m_sel = wd & 1;
    if (we && a == 8'hBF) m_page = wd & 8'hFF;
    @(negedge clk);
    check(tag, int'(sfr_rdata), m_rd);
  endtask

  task automatic rd(int a);
    step(0, 0, 0, 0, a, 0, 0, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1; ptr_load = 0; ptr_load_val = 0; ptr_inc = 0; sfr_we = 0;
    sfr_addr = 0; sfr_wdata = 0; xaddr_indirect = 0; ri_val = 0;
    m_ptr[0] = 0; m_ptr[1] = 0; m_sel = 0; m_page = 0; m_rd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state
    check("R1", int'(sfr_rdata), 0);
    check("R1", int'(xaddr), 0);
    tag = "R1"; rd(8'h82); rd(8'hBF);

    // R4 / R3: load each pointer, toggle select back and forth
    tag = "R4";
    step(1, 16'h1234, 0, 0, 8'h00, 0, 0, 0);
    step(0, 0, 0, 1, 8'h92, 8'h01, 0, 0);
    step(1, 16'hABCD, 0, 0, 8'h83, 0, 0, 0);
    tag = "R3";
    step(0, 0, 0, 1, 8'h92, 8'h00, 0, 0);
    rd(8'h83); rd(8'h82);
    step(0, 0, 0, 1, 8'h92, 8'h01, 0, 0);
    rd(8'h83); rd(8'h82);

    // R2: upper select bits ignored
    tag = "R2";
    step(0, 0, 0, 1, 8'h92, 8'hFE, 0, 0);
    rd(8'h92);
    step(0, 0, 0, 1, 8'h92, 8'hFF, 0, 0);
    rd(8'h92);

    // R5: increment and wrap on pointer 1, pointer 0 untouched
    tag = "R5";
    step(1, 16'hFFFF, 0, 0, 8'h00, 0, 0, 0);
    step(0, 0, 1, 0, 8'h82, 0, 0, 0);
    rd(8'h83);
    step(0, 0, 0, 1, 8'h92, 8'h00, 0, 0);
    rd(8'h82); rd(8'h83);

    // R6: byte writes to selected pointer
    tag = "R6";
    step(0, 0, 0, 1, 8'h82, 8'h5A, 0, 0);
    rd(8'h82); rd(8'h83);
    step(0, 0, 0, 1, 8'h83, 8'hC3, 0, 0);
    rd(8'h83);
    step(0, 0, 0, 1, 8'h92, 8'h01, 0, 0);
    rd(8'h82);

    // R11 / R9: page register and indirect address
    tag = "R11";
    step(0, 0, 0, 1, 8'hBF, 8'h7E, 0, 0);
    rd(8'hBF);
    step(0, 0, 0, 0, 8'h00, 0, 1, 8'h44);
    step(0, 0, 0, 0, 8'h00, 0, 1, 8'hFF);

    // R7: unimplemented addresses read zero
    tag = "R7";
    rd(8'h81); rd(8'h00); rd(8'hFF); rd(8'h84);

    // R10: same-cycle priority
    tag = "R10";
    step(1, 16'h0102, 1, 1, 8'h82, 8'hEE, 0, 0);
    rd(8'h82);
    step(0, 0, 1, 1, 8'h83, 8'hEE, 0, 0);
    rd(8'h83); rd(8'h82);
    step(1, 16'h3030, 0, 1, 8'h92, 8'h00, 0, 0);
    rd(8'h82);

    // mixed traffic against the model
    tag = "R7";
    for (int i = 0; i < 400; i++) begin
      int pick, a;
      pick = $urandom_range(0, 5);
      case (pick)
        0: a = 8'h82; 1: a = 8'h83; 2: a = 8'h92; 3: a = 8'hBF;
        default: a = $urandom_range(0, 255);
      endcase
      step($urandom_range(0, 5) == 0, $urandom_range(0, 65535),
           $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, a,
           $urandom_range(0, 255), $urandom_range(0, 1) == 1,
           $urandom_range(0, 255));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule